// File: doc/BRIEF.md
# Constant-Tick Countdown Timer

A per-core countdown timer paced by a fixed-rate tick. The tick normally comes every 10 ns, a 100 MHz rate, and here arrives as a one-cycle enable strobe. Software programs the timer through one configuration word. Bit 0 of that word turns the countdown on. Bit 1 picks periodic or one-shot operation. The rest of the low field, taken in place with its two lowest bits forced to zero, is the start count.

Each tick lowers the live remaining count by one while the timer runs. When the count runs out the timer expires. In periodic mode it then reloads from the stored word and keeps going. In one-shot mode it clears the enable bit of the stored word by itself and stops. Every expiry raises a level interrupt, which holds until a clear pulse arrives.

A free-running stamp counter reports how many ticks have passed since reset. The stored word, the live remaining count and the stamp can all be read back at any time.

Top module: `ctick_timer`

## Requirements
- R1: After reset the stored word, the remaining count, the stamp and the interrupt are all zero.
- R2: A write with bit 0 set stores the whole word. The remaining count becomes the word ANDed with a mask of bits CNT_HI..2. Bits 1..0 and any bits above CNT_HI add nothing to the count.
- R3: While bit 0 of the stored word is set, each tick lowers the remaining count by one while the count is above one. A cycle with no tick leaves it unchanged.
- R4: The timer expires on a tick that finds the remaining count at 1 or 0. So a start count N≥1 expires on the Nth tick, and a start count of 0 expires on the first tick. The interrupt reads high in the cycle after that tick's edge.
- R5: On expiry with bit 1 set, the remaining count reloads from the masked stored word and bit 0 stays set.
- R6: On expiry with bit 1 clear, bit 0 of the stored word clears while its other bits keep their values, and the remaining count goes to 0. Later ticks change nothing.
- R7: A write with bit 0 clear stores the word and freezes the remaining count at its current value. Later ticks neither change it nor raise the interrupt.
- R8: The interrupt stays high until a cycle with the clear input high and no expiry. If a clear and an expiry fall in the same cycle, the interrupt stays high.
- R9: The stamp goes up by one on every tick, whether or not the timer is enabled.
- R10: When a write and a tick fall in the same cycle, the write decides the remaining count and the tick does not count it down. The stamp still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle tick strobe (the constant-rate time base) |
| wr_en_i | input | 1 | Write strobe for the configuration word |
| wr_data_i | input | CFG_W | Configuration word to store |
| irq_clr_i | input | 1 | Clears the interrupt |
| cfg_o | output | CFG_W | Stored configuration word |
| remain_o | output | CNT_HI+1 | Ticks left before the next expiry |
| stamp_o | output | STAMP_W | Ticks since reset |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench sweeps every start count from 0 to 40 and the largest count, all in one-shot mode. Some of these words also carry bits above the count field. An off-by-one in the expiry point would make the interrupt appear one tick early or late, and a mask error would load the wrong count. Periodic runs check that the count reloads and that the enable bit survives, including a zero count that expires on every tick. Directed cases put a clear on the same cycle as an expiry, and a write on the same cycle as a tick. A design that let the clear win would drop the interrupt. One that let the tick win would load a count one lower than written.

// File: rtl/ctick_pkg.sv
package ctick_pkg;

  // Start count kept in place: bits hi..2 of the word, the rest zero.
  function automatic logic [63:0] load_field(input logic [63:0] word, input int hi);
    logic [63:0] r;
    r = '0;
    for (int i = 2; i < 64; i++) begin
      if (i <= hi) r[i] = word[i];
    end
    return r;
  endfunction

  // A tick expires the timer when at most one tick is left.
  function automatic logic at_end(input logic [63:0] remain);
    return (remain <= 64'd1);
  endfunction

endpackage

// File: rtl/ctick_cfg_reg.sv
module ctick_cfg_reg #(
  parameter int CFG_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             oneshot_done,
  output logic [CFG_W-1:0] cfg_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_en) begin
      cfg_q <= wr_data;
    end else if (oneshot_done) begin
      cfg_q <= {cfg_q[CFG_W-1:1], 1'b0};
    end
  end

  // R6
  oneshot_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oneshot_done && !wr_en) |=> (!cfg_q[0] && cfg_q[CFG_W-1:1] == $past(cfg_q[CFG_W-1:1])));

  // R2
  write_stores_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cfg_q == $past(wr_data)));

endmodule

// File: rtl/ctick_down.sv
module ctick_down
  import ctick_pkg::*;
#(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             periodic,
  input  logic             wr_en,
  input  logic             wr_enable,
  input  logic [CNT_W-1:0] wr_load,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] remain_q,
  output logic             expire
);

  logic counting;

  assign counting = run && tick && !wr_en;
  assign expire   = counting && at_end(64'(remain_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain_q <= '0;
    end else if (wr_en) begin
      if (wr_enable) remain_q <= wr_load;
    end else if (expire) begin
      remain_q <= periodic ? reload : '0;
    end else if (counting) begin
      remain_q <= remain_q - CNT_W'(1);
    end
  end

  // R3
  decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (counting && remain_q > CNT_W'(1)) |=> (remain_q == $past(remain_q) - CNT_W'(1)));

  // R7
  frozen_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_en) |=> $stable(remain_q));

  // R5
  periodic_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && periodic) |=> (remain_q == $past(reload)));

  // R10
  write_beats_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_enable) |=> (remain_q == $past(wr_load)));

endmodule

// File: rtl/ctick_irq.sv
module ctick_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clr,
  output logic irq_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)      irq_q <= 1'b0;
    else if (expire) irq_q <= 1'b1;
    else if (clr)    irq_q <= 1'b0;
  end

  // R8
  expire_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> irq_q);

  // R8
  clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !expire) |=> !irq_q);

  // R4
  rise_needs_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(expire));

endmodule

// File: rtl/ctick_stamp.sv
module ctick_stamp #(
  parameter int STAMP_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  output logic [STAMP_W-1:0] stamp_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)    stamp_q <= '0;
    else if (tick) stamp_q <= stamp_q + STAMP_W'(1);
  end

  // R9
  stamp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (stamp_q == $past(stamp_q) + STAMP_W'(1)));

  // R9
  stamp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(stamp_q));

endmodule

// File: rtl/ctick_timer.sv
module ctick_timer
  import ctick_pkg::*;
#(
  parameter int CFG_W   = 64,
  parameter int CNT_HI  = 47,
  parameter int STAMP_W = 64,
  localparam int CNT_W  = CNT_HI + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic               wr_en_i,
  input  logic [CFG_W-1:0]   wr_data_i,
  input  logic               irq_clr_i,
  output logic [CFG_W-1:0]   cfg_o,
  output logic [CNT_W-1:0]   remain_o,
  output logic [STAMP_W-1:0] stamp_o,
  output logic               irq_o
);

  logic [CFG_W-1:0] cfg_q;
  logic [CNT_W-1:0] wr_load;
  logic [CNT_W-1:0] reload;
  logic             expire;
  logic             oneshot_done;

  assign wr_load      = CNT_W'(load_field(64'(wr_data_i), CNT_HI));
  assign reload       = CNT_W'(load_field(64'(cfg_q), CNT_HI));
  assign oneshot_done = expire && !cfg_q[1];

  ctick_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_data(wr_data_i),
    .oneshot_done(oneshot_done), .cfg_q(cfg_q)
  );

  ctick_down #(.CNT_W(CNT_W)) u_down (
    .clk(clk), .rst_n(rst_n), .tick(tick_i), .run(cfg_q[0]),
    .periodic(cfg_q[1]), .wr_en(wr_en_i), .wr_enable(wr_data_i[0]),
    .wr_load(wr_load), .reload(reload), .remain_q(remain_o), .expire(expire)
  );

  ctick_irq u_irq (
    .clk(clk), .rst_n(rst_n), .expire(expire), .clr(irq_clr_i), .irq_q(irq_o)
  );

  ctick_stamp #(.STAMP_W(STAMP_W)) u_stamp (
    .clk(clk), .rst_n(rst_n), .tick(tick_i), .stamp_q(stamp_o)
  );

  assign cfg_o = cfg_q;

  // R6
  oneshot_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oneshot_done && !wr_en_i) |=> (remain_o == '0 && !cfg_o[0]));

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (cfg_o == '0 && remain_o == '0 && stamp_o == '0 && !irq_o));

endmodule

// File: tb/sim_ctick_timer.sv
module sim_ctick_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        irq_clr = 1'b0;
  logic [15:0] cfg;
  logic [9:0]  remain;
  logic [15:0] stamp;
  logic        irq;

  int compared = 0;
  int mismatched = 0;
  int exp_stamp = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ctick_timer #(.CFG_W(16), .CNT_HI(9), .STAMP_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .irq_clr_i(irq_clr), .cfg_o(cfg),
    .remain_o(remain), .stamp_o(stamp), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, let the edge pass, sample at the next negedge.
  task automatic cyc(input logic t, input logic w, input logic [15:0] d, input logic c);
    tick = t; wr_en = w; wr_data = d; irq_clr = c;
    @(posedge clk);
    @(negedge clk);
    tick = 0; wr_en = 0; irq_clr = 0;
    if (t) exp_stamp++;
  endtask

  function automatic logic [15:0] masked(input logic [15:0] w);
    return w & 16'h03FC;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 cfg", 64'(cfg), 0);
    chk("R1 remain", 64'(remain), 0);
    chk("R1 stamp", 64'(stamp), 0);
    chk("R1 irq", 64'(irq), 0);

    // R2 R4 R6: one-shot sweep over start counts
    for (int c = 0; c <= 41; c++) begin
      int cv = (c == 41) ? 255 : c;
      logic [15:0] w = 16'(cv * 4) | 16'h0001 | ((c % 2 == 1) ? 16'hFC00 : 16'h0000);
      int r = int'(masked(w));
      int need = (r == 0) ? 1 : r;
      cyc(0, 1, w, 0);
      chk("R2 cfg stored", 64'(cfg), 64'(w));
      chk("R2 load", 64'(remain), 64'(r));
      for (int k = 1; k < need; k++) begin
        cyc(1, 0, 0, 0);
        chk("R3 count", 64'(remain), 64'(r - k));
        chk("R4 no early irq", 64'(irq), 0);
      end
      cyc(1, 0, 0, 0);
      chk("R4 irq at expiry", 64'(irq), 1);
      chk("R6 remain zero", 64'(remain), 0);
      chk("R6 en cleared", 64'(cfg), 64'(w & 16'hFFFE));
      cyc(1, 0, 0, 0);
      chk("R6 stopped", 64'(remain), 0);
      chk("R8 irq held", 64'(irq), 1);
      cyc(0, 0, 0, 1);
      chk("R8 irq cleared", 64'(irq), 0);
    end

    // R5: periodic, start count 12
    cyc(0, 1, 16'h000F, 0);
    for (int p = 0; p < 3; p++) begin
      for (int k = 1; k <= 12; k++) cyc(1, 0, 0, 0);
      chk("R5 irq each period", 64'(irq), 1);
      chk("R5 reload", 64'(remain), 12);
      chk("R5 en kept", 64'(cfg), 16'h000F);
      cyc(0, 0, 0, 1);
      chk("R8 clear", 64'(irq), 0);
    end

    // R5 R8: periodic zero count expires every tick; clear loses to expiry
    cyc(0, 1, 16'h0003, 0);
    cyc(1, 0, 0, 0);
    chk("R5 zero periodic", 64'(irq), 1);
    cyc(1, 0, 0, 1);
    chk("R8 expiry beats clear", 64'(irq), 1);
    chk("R5 zero stays enabled", 64'(cfg), 3);
    cyc(0, 1, 16'h0000, 0);
    cyc(0, 0, 0, 1);
    chk("R8 clear after stop", 64'(irq), 0);
    for (int k = 0; k < 4; k++) cyc(1, 0, 0, 0);
    chk("R7 no irq when off", 64'(irq), 0);
    chk("R7 remain off", 64'(remain), 0);

    // R7: stop mid count
    cyc(0, 1, 16'h0041, 0);
    for (int k = 0; k < 10; k++) cyc(1, 0, 0, 0);
    chk("R3 mid count", 64'(remain), 54);
    cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 0);
    chk("R3 hold without tick", 64'(remain), 54);
    cyc(0, 1, 16'h0040, 0);
    chk("R7 cfg stored", 64'(cfg), 16'h0040);
    chk("R7 frozen", 64'(remain), 54);
    for (int k = 0; k < 5; k++) cyc(1, 0, 0, 0);
    chk("R7 still frozen", 64'(remain), 54);
    chk("R7 no irq", 64'(irq), 0);

    // R2: restart mid count
    cyc(0, 1, 16'h0041, 0);
    for (int k = 0; k < 10; k++) cyc(1, 0, 0, 0);
    cyc(0, 1, 16'h0021, 0);
    chk("R2 restart", 64'(remain), 32);

    // R10: write and tick in the same cycle
    cyc(1, 1, 16'h0011, 0);
    chk("R10 write wins", 64'(remain), 16);
    cyc(1, 0, 0, 0);
    chk("R10 next tick counts", 64'(remain), 15);

    // R9
    chk("R9 stamp", 64'(stamp), 64'(exp_stamp & 16'hFFFF));

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule